// File: doc/BRIEF.md
# Nonvolatile Store/Restore Sequencer

This block models a small nonvolatile array of sixteen 16-bit words behind a digitally controlled two-channel resistor, and it orders every access to that array. A command executor hands it single-cycle requests: save a wiper setting or a user word, reload one or both wiper registers from their saved entries, or read a saved word or the live wiper value back for serial output. The block answers with load strobes and values for the two wiper registers, a read strobe with data, a `ready` output that drops for the length of each slow operation, and a `busy` output that holds the serial receiver still while a save is in progress.

Words 0 and 1 keep the saved setting for channel 0 and channel 1; words 2 to 14 belong to the user; word 15 is a fixed, read-only tolerance value. Reset stands for power-on. It puts the array in its factory state, with midscale in both wiper entries, and then reloads both wipers after a power-up delay. A preset pin, active low, forces both wipers to midscale while it is held low. When it is released, the block waits and then reloads the saved values. A write-protect input, also active low, blocks saves but never blocks reloads. Every duration is a parameter given in clock cycles.

Top module: `nvs_seq`

## Requirements
- R1: After reset is released, `ready` stays low for PWRUP_CYC cycles. In the cycle after that, `ld_valid` is 2'b11 and both load values equal the saved words 0 and 1, which are midscale (2^(WIPER_W-1)) in the factory state.
- R2: Op code 2 (save wiper) with address 0 or 1 holds `ready` low and `busy` high for STORE_CYC cycles. It then writes the live value of that channel's wiper, zero-extended, into word 0 or word 1.
- R3: Op code 3 (save) with an address from 2 to 14 writes `req_data` into that word, using the same STORE_CYC timing. With address 0 or 1 it saves that channel's wiper instead.
- R4: A save to address 15 is ignored. `ready` stays high and word 15 keeps reading TOL_VALUE.
- R5: While `wp_n` is low, a save request is ignored (`ready` stays high and the word is unchanged). Reloads still work.
- R6: Op code 1 (reload one) with address 0 or 1 raises only that channel's bit of `ld_valid` (bit 0 is channel 0) in the next cycle, carrying the saved value. `ready` does not drop.
- R7: Op code 8 (reload both) holds `ready` low for RESTORE_CYC cycles. In the cycle after that, `ld_valid` is 2'b11 with both saved values.
- R8: Op code 9 (read word) and op code 10 (read wiper, address 0 or 1) hold `ready` low for READ_CYC cycles with `busy` low. In the cycle after that, `rd_valid` pulses, carrying the addressed word or the wiper value captured when the request was taken.
- R9: While `preset_n` is low, every cycle carries `ld_valid` = 2'b11 with midscale on both channels, and `ready` is low. After the pin rises, `ready` stays low for PRESET_CYC+1 cycles, and `ld_valid` = 2'b11 then carries the saved values.
- R10: A request that arrives while `ready` is low, or while `preset_n` is low, is dropped. `err` is high in the next cycle.
- R11: `busy` is high only while a save is pending, and never while `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_op | input | 4 | Operation code (1, 2, 3, 8, 9, 10) |
| req_addr | input | 4 | Word or channel address |
| req_data | input | DATA_W | User word for op code 3 |
| wiper0_cur | input | WIPER_W | Live wiper register of channel 0 |
| wiper1_cur | input | WIPER_W | Live wiper register of channel 1 |
| wp_n | input | 1 | Write protect, active low |
| preset_n | input | 1 | Preset pin, active low |
| ld_valid | output | 2 | Per-channel wiper load strobe |
| ld_val0 | output | WIPER_W | Load value for channel 0 |
| ld_val1 | output | WIPER_W | Load value for channel 1 |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DATA_W | Read data |
| ready | output | 1 | High when idle |
| busy | output | 1 | High while a save is pending |
| err | output | 1 | Dropped-request pulse |

## Verification
The checker assumes that `preset_n`, `wp_n` and the request inputs are synchronous to `clk` and change away from its rising edge. It also assumes that the executor holds `req_valid` for only one cycle at a time. The bench drives every input on the falling edge and raises `req_valid` for exactly one cycle per request. Apart from the dropped-request case, it waits for `ready` before issuing the next request. The preset pin is moved only between requests, so the stimulus stays inside what the properties expect.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
   localparam logic [3:0] OP_REST_ONE = 4'd1;
   localparam logic [3:0] OP_SAVE_WIP = 4'd2;
   localparam logic [3:0] OP_SAVE_ANY = 4'd3;
   localparam logic [3:0] OP_REST_ALL = 4'd8;
   localparam logic [3:0] OP_RD_WORD  = 4'd9;
   localparam logic [3:0] OP_RD_WIP   = 4'd10;

   typedef enum logic [2:0] {
      ST_PWRUP,
      ST_IDLE,
      ST_WAIT,
      ST_PHOLD,
      ST_PWAIT
   } nvs_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/nvs_timer.sv
module nvs_timer #(
   parameter int CNT_W = 8,
   parameter int INIT  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= CNT_W'(INIT);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
   parameter int          DATA_W    = 16,
   parameter int          ADDR_W    = 4,
   parameter int          WIPER_W   = 10,
   parameter logic [15:0] TOL_VALUE = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] word0,
   output logic [DATA_W-1:0] word1
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int LAST  = DEPTH - 1;
   localparam logic [DATA_W-1:0] MID_WORD = DATA_W'(1) << (WIPER_W - 1);

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      if (i == LAST) begin : g_fixed
         assign words[i] = DATA_W'(TOL_VALUE);
      end else begin : g_cell
         localparam logic [DATA_W-1:0] FACTORY = (i < 2) ? MID_WORD : '0;
         logic [DATA_W-1:0] cell_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cell_q <= FACTORY;
            else if (we && (waddr == ADDR_W'(i)))
               cell_q <= wdata;
         end
         assign words[i] = cell_q;
      end
   end

   assign rdata = words[raddr];
   assign word0 = words[0];
   assign word1 = words[1];
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
   import nvs_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 4,
   parameter int WIPER_W     = 10,
   parameter int CNT_W       = 8,
   parameter int STORE_CYC   = 4,
   parameter int RESTORE_CYC = 4,
   parameter int READ_CYC    = 4,
   parameter int PRESET_CYC  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [3:0]         req_op,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_data,
   input  logic [WIPER_W-1:0] wiper0_cur,
   input  logic [WIPER_W-1:0] wiper1_cur,
   input  logic               wp_n,
   input  logic               preset_n,
   input  logic               tdone,
   output logic               tload,
   output logic [CNT_W-1:0]   tval,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_waddr,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic [ADDR_W-1:0]  mem_raddr,
   input  logic [DATA_W-1:0]  mem_rdata,
   input  logic [DATA_W-1:0]  word0,
   input  logic [DATA_W-1:0]  word1,
   output logic [1:0]         ld_valid,
   output logic [WIPER_W-1:0] ld_val0,
   output logic [WIPER_W-1:0] ld_val1,
   output logic               rd_valid,
   output logic [DATA_W-1:0]  rd_data,
   output logic               ready,
   output logic               busy,
   output logic               err
);
   localparam logic [ADDR_W-1:0]  LAST_ADDR = '1;
   localparam logic [WIPER_W-1:0] MID       = WIPER_W'(1) << (WIPER_W - 1);

   nvs_state_e        state_q;
   logic [3:0]        pend_op_q;
   logic [ADDR_W-1:0] pend_addr_q;
   logic [DATA_W-1:0] pend_wdata_q;

   logic               idle, low_addr, known, ignored, accept, pend_save;
   logic [WIPER_W-1:0] live_wiper;
   logic [DATA_W-1:0]  capture;

   assign idle       = (state_q == ST_IDLE);
   assign low_addr   = (req_addr < ADDR_W'(2));
   assign live_wiper = req_addr[0] ? wiper1_cur : wiper0_cur;

   always_comb begin
      known   = 1'b1;
      ignored = 1'b0;
      unique case (req_op)
         OP_REST_ONE: ignored = !low_addr;
         OP_SAVE_WIP: ignored = !wp_n || !low_addr;
         OP_SAVE_ANY: ignored = !wp_n || (req_addr == LAST_ADDR);
         OP_REST_ALL: ignored = 1'b0;
         OP_RD_WORD:  ignored = 1'b0;
         OP_RD_WIP:   ignored = !low_addr;
         default:     known   = 1'b0;
      endcase
   end

   assign accept = req_valid && idle && preset_n && known && !ignored;

   // Word captured at acceptance: live wiper for wiper saves and wiper reads
   always_comb begin
      if ((req_op == OP_SAVE_ANY) && !low_addr)
         capture = req_data;
      else
         capture = DATA_W'(live_wiper);
   end

   // Timer reload selection
   always_comb begin
      tload = 1'b0;
      tval  = '0;
      if (state_q == ST_PHOLD && preset_n) begin
         tload = 1'b1;
         tval  = CNT_W'(PRESET_CYC - 1);
      end else if (accept) begin
         unique case (req_op)
            OP_SAVE_WIP, OP_SAVE_ANY: begin
               tload = 1'b1;
               tval  = CNT_W'(STORE_CYC - 1);
            end
            OP_REST_ALL: begin
               tload = 1'b1;
               tval  = CNT_W'(RESTORE_CYC - 1);
            end
            OP_RD_WORD, OP_RD_WIP: begin
               tload = 1'b1;
               tval  = CNT_W'(READ_CYC - 1);
            end
            default: tload = 1'b0;
         endcase
      end
   end

   assign pend_save = (pend_op_q == OP_SAVE_WIP) || (pend_op_q == OP_SAVE_ANY);
   assign mem_we    = (state_q == ST_WAIT) && tdone && preset_n && pend_save;
   assign mem_waddr = pend_addr_q;
   assign mem_wdata = pend_wdata_q;
   assign mem_raddr = pend_addr_q;
   assign ready     = idle;
   assign busy      = (state_q == ST_WAIT) && pend_save;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_PWRUP;
         pend_op_q    <= '0;
         pend_addr_q  <= '0;
         pend_wdata_q <= '0;
         ld_valid     <= 2'b00;
         ld_val0      <= '0;
         ld_val1      <= '0;
         rd_valid     <= 1'b0;
         rd_data      <= '0;
         err          <= 1'b0;
      end else begin
         ld_valid <= 2'b00;
         rd_valid <= 1'b0;
         err      <= req_valid && !(idle && preset_n);
         if (!preset_n) begin
            state_q  <= ST_PHOLD;
            ld_valid <= 2'b11;
            ld_val0  <= MID;
            ld_val1  <= MID;
         end else begin
            unique case (state_q)
               ST_PWRUP, ST_PWAIT: begin
                  if (tdone) begin
                     ld_valid <= 2'b11;
                     ld_val0  <= word0[WIPER_W-1:0];
                     ld_val1  <= word1[WIPER_W-1:0];
                     state_q  <= ST_IDLE;
                  end
               end
               ST_PHOLD: state_q <= ST_PWAIT;
               ST_IDLE: begin
                  if (accept) begin
                     if (req_op == OP_REST_ONE) begin
                        if (req_addr[0]) begin
                           ld_valid <= 2'b10;
                           ld_val1  <= word1[WIPER_W-1:0];
                        end else begin
                           ld_valid <= 2'b01;
                           ld_val0  <= word0[WIPER_W-1:0];
                        end
                     end else begin
                        state_q      <= ST_WAIT;
                        pend_op_q    <= req_op;
                        pend_addr_q  <= req_addr;
                        pend_wdata_q <= capture;
                     end
                  end
               end
               ST_WAIT: begin
                  if (tdone) begin
                     state_q <= ST_IDLE;
                     if (pend_op_q == OP_REST_ALL) begin
                        ld_valid <= 2'b11;
                        ld_val0  <= word0[WIPER_W-1:0];
                        ld_val1  <= word1[WIPER_W-1:0];
                     end else if (pend_op_q == OP_RD_WORD) begin
                        rd_valid <= 1'b1;
                        rd_data  <= mem_rdata;
                     end else if (pend_op_q == OP_RD_WIP) begin
                        rd_valid <= 1'b1;
                        rd_data  <= pend_wdata_q;
                     end
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
   import nvs_pkg::*;
#(
   parameter int          DATA_W      = 16,
   parameter int          ADDR_W      = 4,
   parameter int          WIPER_W     = 10,
   parameter int          STORE_CYC   = 1875000,
   parameter int          RESTORE_CYC = 2500,
   parameter int          READ_CYC    = 875,
   parameter int          PRESET_CYC  = 3750,
   parameter int          PWRUP_CYC   = 3750,
   parameter logic [15:0] TOL_VALUE   = 16'h0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [3:0]         req_op,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_data,
   input  logic [WIPER_W-1:0] wiper0_cur,
   input  logic [WIPER_W-1:0] wiper1_cur,
   input  logic               wp_n,
   input  logic               preset_n,
   output logic [1:0]         ld_valid,
   output logic [WIPER_W-1:0] ld_val0,
   output logic [WIPER_W-1:0] ld_val1,
   output logic               rd_valid,
   output logic [DATA_W-1:0]  rd_data,
   output logic               ready,
   output logic               busy,
   output logic               err
);
   localparam int MAX_CYC = max2(max2(max2(STORE_CYC, RESTORE_CYC), max2(READ_CYC, PRESET_CYC)), PWRUP_CYC);
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   if (WIPER_W > DATA_W) begin : g_bad_w
      $error("WIPER_W must not exceed DATA_W");
   end
   if (ADDR_W != 4) begin : g_bad_a
      $error("ADDR_W must be 4: words 2..14 user, 15 fixed");
   end
   if (STORE_CYC < 1 || RESTORE_CYC < 1 || READ_CYC < 1 || PRESET_CYC < 1 || PWRUP_CYC < 1) begin : g_bad_c
      $error("all durations must be at least one cycle");
   end

   logic              tload, tdone, mem_we;
   logic [CNT_W-1:0]  tval;
   logic [ADDR_W-1:0] mem_waddr, mem_raddr;
   logic [DATA_W-1:0] mem_wdata, mem_rdata, word0, word1;

   nvs_timer #(.CNT_W(CNT_W), .INIT(PWRUP_CYC - 1)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tload), .load_val(tval), .done(tdone)
   );

   nvs_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIPER_W(WIPER_W), .TOL_VALUE(TOL_VALUE)) u_array (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .raddr(mem_raddr), .rdata(mem_rdata), .word0(word0), .word1(word1)
   );

   nvs_ctrl #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIPER_W(WIPER_W), .CNT_W(CNT_W),
      .STORE_CYC(STORE_CYC), .RESTORE_CYC(RESTORE_CYC),
      .READ_CYC(READ_CYC), .PRESET_CYC(PRESET_CYC)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .wiper0_cur(wiper0_cur),
      .wiper1_cur(wiper1_cur), .wp_n(wp_n), .preset_n(preset_n),
      .tdone(tdone), .tload(tload), .tval(tval),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .word0(word0), .word1(word1),
      .ld_valid(ld_valid), .ld_val0(ld_val0), .ld_val1(ld_val1),
      .rd_valid(rd_valid), .rd_data(rd_data), .ready(ready), .busy(busy), .err(err)
   );
endmodule

// File: rtl/nvs_seq_chk.sv
module nvs_seq_chk #(
   parameter int WIPER_W = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               wp_n,
   input logic               preset_n,
   input logic               ready,
   input logic               busy,
   input logic               err,
   input logic [1:0]         ld_valid,
   input logic [WIPER_W-1:0] ld_val0,
   input logic [WIPER_W-1:0] ld_val1,
   input logic               rd_valid
);
   localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1);

   // R9
   preset_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !preset_n |=> (ld_valid == 2'b11 && ld_val0 == MID && ld_val1 == MID));

   // R9
   preset_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !preset_n |=> !ready);

   // R5
   wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(wp_n) && $past(req_valid)));

   // R11
   busy_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ready);

   // R10
   drop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !ready) |=> err);

   // R8
   rd_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!ready));
endmodule

bind nvs_seq nvs_seq_chk #(.WIPER_W(WIPER_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .wp_n(wp_n),
   .preset_n(preset_n), .ready(ready), .busy(busy), .err(err),
   .ld_valid(ld_valid), .ld_val0(ld_val0), .ld_val1(ld_val1), .rd_valid(rd_valid)
);

// File: tb/nvs_seq_test.sv
module nvs_seq_test;
   localparam int ST = 20, RS = 8, RD = 5, PR = 6, PU = 4;
   localparam logic [15:0] TOL = 16'h0ABC;
   localparam logic [9:0]  MID = 10'd512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_op = '0;
   logic [3:0]  req_addr = '0;
   logic [15:0] req_data = '0;
   logic [9:0]  wiper0_cur = '0, wiper1_cur = '0;
   logic        wp_n = 1'b1, preset_n = 1'b1;
   logic [1:0]  ld_valid;
   logic [9:0]  ld_val0, ld_val1;
   logic        rd_valid, ready, busy, err;
   logic [15:0] rd_data;

   int total = 0, bad = 0, n = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   nvs_seq #(.STORE_CYC(ST), .RESTORE_CYC(RS), .READ_CYC(RD), .PRESET_CYC(PR),
             .PWRUP_CYC(PU), .TOL_VALUE(TOL)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .wiper0_cur(wiper0_cur),
      .wiper1_cur(wiper1_cur), .wp_n(wp_n), .preset_n(preset_n),
      .ld_valid(ld_valid), .ld_val0(ld_val0), .ld_val1(ld_val1),
      .rd_valid(rd_valid), .rd_data(rd_data), .ready(ready), .busy(busy), .err(err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [3:0] op, input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_rdy(output int cnt);
      cnt = 0;
      while (!ready && cnt < 1000) begin
         @(negedge clk);
         cnt++;
      end
   endtask

   task automatic read_word(input logic [3:0] a, input logic [15:0] exp, input string tag);
      int c;
      send(4'd9, a, '0);
      wait_rdy(c);
      chk(rd_valid && rd_data == exp, tag, rd_data, exp);
   endtask

   task automatic t_powerup();
      @(negedge clk); @(negedge clk);
      chk(ready == 1'b0, "R1 ready low in reset", ready, 0);
      rst_n = 1'b1;
      wait_rdy(n);
      chk(n == PU, "R1 power-up cycles", n, PU);
      chk(ld_valid == 2'b11 && ld_val0 == MID && ld_val1 == MID, "R1 factory reload", ld_val0, MID);
   endtask

   task automatic t_save_wiper();
      int c;
      wiper0_cur = 10'h155;
      send(4'd2, 4'd0, '0);
      chk(busy && !ready, "R2 busy during save", busy, 1);
      wait_rdy(c);
      chk(c == ST, "R2 save cycles", c, ST);
      read_word(4'd0, 16'h0155, "R2 saved wiper word");
   endtask

   task automatic t_save_user();
      int c;
      send(4'd3, 4'd5, 16'hBEEF);
      wait_rdy(c);
      chk(c == ST, "R3 user save cycles", c, ST);
      read_word(4'd5, 16'hBEEF, "R3 user word");
   endtask

   task automatic t_save_fixed();
      send(4'd3, 4'd15, 16'h1234);
      chk(ready && !busy, "R4 save to 15 ignored", ready, 1);
      read_word(4'd15, TOL, "R4 word 15 intact");
   endtask

   task automatic t_wp();
      int c;
      wp_n = 1'b0;
      send(4'd3, 4'd6, 16'h7777);
      chk(ready && !busy, "R5 protected save ignored", ready, 1);
      read_word(4'd6, 16'h0000, "R5 word unchanged");
      send(4'd8, 4'd0, '0);
      wait_rdy(c);
      chk(ld_valid == 2'b11 && ld_val0 == 10'h155, "R5 reload under protect", ld_val0, 10'h155);
      wp_n = 1'b1;
   endtask

   task automatic t_rest_one();
      send(4'd1, 4'd0, '0);
      chk(ld_valid == 2'b01 && ld_val0 == 10'h155 && ready, "R6 reload channel 0", ld_valid, 1);
      send(4'd1, 4'd1, '0);
      chk(ld_valid == 2'b10 && ld_val1 == MID, "R6 reload channel 1", ld_valid, 2);
   endtask

   task automatic t_rest_all();
      int c;
      send(4'd8, 4'd0, '0);
      wait_rdy(c);
      chk(c == RS, "R7 reload cycles", c, RS);
      chk(ld_valid == 2'b11 && ld_val0 == 10'h155 && ld_val1 == MID, "R7 reload values", ld_val0, 10'h155);
   endtask

   task automatic t_rd_wiper();
      int c;
      wiper1_cur = 10'h3FF;
      send(4'd10, 4'd1, '0);
      chk(!busy && !ready, "R11 no busy on read", busy, 0);
      wiper1_cur = 10'h001;
      wait_rdy(c);
      chk(c == RD, "R8 read cycles", c, RD);
      chk(rd_valid && rd_data == 16'h03FF, "R8 read wiper", rd_data, 16'h03FF);
   endtask

   task automatic t_preset();
      int c;
      @(negedge clk);
      preset_n = 1'b0;
      @(negedge clk);
      chk(ld_valid == 2'b11 && ld_val0 == MID && ld_val1 == MID && !ready, "R9 forced midscale", ld_val0, MID);
      repeat (3) @(negedge clk);
      chk(ld_valid == 2'b11 && ld_val0 == MID, "R9 held midscale", ld_val0, MID);
      preset_n = 1'b1;
      wait_rdy(c);
      chk(c == PR + 1, "R9 release cycles", c, PR + 1);
      chk(ld_valid == 2'b11 && ld_val0 == 10'h155 && ld_val1 == MID, "R9 saved reload", ld_val0, 10'h155);
   endtask

   task automatic t_drop();
      int c;
      send(4'd2, 4'd1, '0);
      send(4'd9, 4'd0, '0);
      chk(err == 1'b1, "R10 drop while busy", err, 1);
      wait_rdy(c);
      chk(!rd_valid, "R10 dropped read absent", rd_valid, 0);
      @(negedge clk);
      chk(err == 1'b0, "R10 err cleared", err, 0);
      read_word(4'd1, 16'h0001, "R10 save completed");
   endtask

   initial begin
      t_powerup();
      t_save_wiper();
      t_save_user();
      t_save_fixed();
      t_wp();
      t_rest_one();
      t_rest_all();
      t_rd_wiper();
      t_preset();
      t_drop();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule